// File: doc/BRIEF.md
# Delay-Multiply Tone Discriminator

This block turns a stream of signed 8-bit audio samples, taken at 9600 samples per second and carrying two-tone frequency-shift keying at 1200 baud (eight samples per bit), into one hard decision per sample. It multiplies each new sample by the sample that arrived four strobes earlier, which is half a bit period. For the 1200 Hz mark tone that lag is half a cycle, so the product comes out negative. For the higher space tone the product comes out mostly positive.

The product is scaled down by an arithmetic right shift of two. It is then smoothed by a first-order recursive low-pass filter that uses only shifts and adds. The sign of the filter output gives the sliced bit. Each sliced bit is shifted into an 8-bit history register so that a later stage can look for transitions. Clock recovery, bit decisions and framing happen downstream.

The feedback coefficient of the filter is chosen once, while the block is held in reset. It is either one half or the shift sum 1/2 + 1/8 + 1/32 (about 0.656).

Top module: `fsk_discrim`

## Requirements
- R1: While reset is held and in the first cycle after it, `bit_o`, `bit_valid_o` and `hist_o` are all zero, and the lag line, filter input and filter output restart from zero.
- R2: `bit_valid_o` is high for exactly one cycle, the cycle after each clock edge on which `smp_valid_i` was high. When `smp_valid_i` is low, `bit_o` and `hist_o` hold their values.
- R3: Each sample is multiplied by the sample accepted four strobes earlier. The four samples after reset are therefore multiplied by zero and give a filter output of zero.
- R4: The filter input x[n] is the signed 16-bit product shifted right arithmetically by two, rounding toward minus infinity. The previous input x[n-1] is kept for the next step.
- R5: With `filt_frac_i` low during reset, y[n] = x[n] + x[n-1] + (y[n-1] >>> 1).
- R6: With `filt_frac_i` high during reset, y[n] = x[n] + x[n-1] + (y[n-1] >>> 1) + (y[n-1] >>> 3) + (y[n-1] >>> 5).
- R7: `bit_o` is 1 only when y[n] is strictly greater than zero. A zero or negative y[n] gives 0.
- R8: On each strobe, `hist_o` shifts left by one and the new sliced bit enters at bit 0.
- R9: `filt_frac_i` is sampled only while `rst_n` is low. Changing it after reset has no effect on the output.
- R10: For any 8-bit input sequence, including full-scale -128, the filter sum fits the 16-bit signed state without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_frac_i | input | 1 | Filter coefficient select, sampled during reset (0: 1/2, 1: 1/2+1/8+1/32) |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 8 | Signed audio sample |
| bit_o | output | 1 | Sliced bit for the last accepted sample |
| bit_valid_o | output | 1 | One-cycle strobe marking a new `bit_o` |
| hist_o | output | 8 | Recent sliced bits, newest at bit 0 |

## Verification
A wrong lag-line slot or a wrong product shift changes the sign of y within a single strobe when the inputs are chosen to sit at the boundary. Such an error therefore appears in `bit_o` on the very next cycle, and in `hist_o[0]` at the same time. A wrong feedback term, or a coefficient that follows the configuration pin after reset, shows up more slowly. It only flips the sign when y[n-1] is large next to x[n] and of opposite sign, so long tone and pseudo-random streams are compared sample by sample against an independent model. Overflow of the state shows as a run of zeros during a full-scale input, where all ones are expected.

// File: rtl/afskd_pkg.sv
// Shared types and defaults for the delay-multiply tone discriminator.
package afskd_pkg;
    // Filter feedback coefficient choice.
    typedef enum logic {
        FILT_HALF = 1'b0,   // y[n-1] * 1/2
        FILT_FRAC = 1'b1    // y[n-1] * (1/2 + 1/8 + 1/32)
    } filt_mode_e;

    localparam int unsigned SMP_W_DEF  = 8;
    localparam int unsigned LAG_DEF    = 4;
    localparam int unsigned ACC_W_DEF  = 16;
    localparam int unsigned HIST_W_DEF = 8;
    localparam int unsigned PSHIFT_DEF = 2;
endpackage

// File: rtl/afskd_delay.sv
// Lag line: holds the last LAG accepted samples.
// tap_o is the sample accepted LAG strobes ago. It is read in the same cycle
// in which din_i is written, so the caller always sees the old value.
// Assumes: shift_i is a single-cycle strobe per sample.
module afskd_delay #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic signed [W-1:0] din_i,
    output logic signed [W-1:0] tap_o
);
    logic signed [W-1:0] stage_q [LAG];

    // Stage 0 loads the new sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q[0] <= '0;
        else if (shift_i) stage_q[0] <= din_i;
    end

    // Each later stage takes the previous one on each strobe.
    for (genvar gi = 1; gi < LAG; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)       stage_q[gi] <= '0;
            else if (shift_i) stage_q[gi] <= stage_q[gi-1];
        end
    end

    assign tap_o = stage_q[LAG-1];

    // R3: a new sample enters stage 0 on every strobe.
    a_r3_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> stage_q[0] == $past(din_i));
    // R2: without a strobe the lag line holds.
    a_r2_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(tap_o));
endmodule

// File: rtl/afskd_lpf.sv
// Product and low-pass stage. It forms x = (a*b) >>> PSHIFT and
// y = x + x_prev + fb(y_prev), where fb is one or three right shifts of y_prev.
// y_next_o is combinational, for slicing in the same step. y_o is the held state.
// Assumes: ACC_W is at least 2*IN_W, so that the sum cannot wrap.
module afskd_lpf
    import afskd_pkg::*;
#(
    parameter int unsigned IN_W   = 8,
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned PSHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_cfg_i,
    input  logic                    step_i,
    input  logic signed [IN_W-1:0]  a_i,
    input  logic signed [IN_W-1:0]  b_i,
    output logic signed [ACC_W-1:0] y_next_o,
    output logic signed [ACC_W-1:0] y_o
);
    localparam int unsigned PROD_W = 2 * IN_W;
    localparam int unsigned WIDE_W = ACC_W + 3;

    filt_mode_e               mode_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  x_new, x_q, y_q, fb;

    // Signed product, then scaled down arithmetically.
    always_comb begin
        prod  = a_i * b_i;
        x_new = ACC_W'(prod >>> PSHIFT);
    end

    // Feedback built from right shifts of the previous output.
    always_comb begin
        fb = y_q >>> 1;
        if (mode_q == FILT_FRAC) fb = fb + (y_q >>> 3) + (y_q >>> 5);
    end

    assign y_next_o = x_new + x_q + fb;
    assign y_o      = y_q;

    // Coefficient select is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= filt_mode_e'(mode_cfg_i);
    end

    // Filter state advances on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (step_i) begin
            x_q <= x_new;
            y_q <= y_next_o;
        end
    end

    // Wide shadow of the sum, used only by the overflow check.
    logic signed [WIDE_W-1:0] sum_wide;
    always_comb begin
        sum_wide = WIDE_W'(x_new) + WIDE_W'(x_q) + WIDE_W'(y_q >>> 1);
        if (mode_q == FILT_FRAC)
            sum_wide = sum_wide + WIDE_W'(y_q >>> 3) + WIDE_W'(y_q >>> 5);
    end

    // R10: the narrow filter sum never differs from the wide one.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> sum_wide == WIDE_W'(y_next_o));
    // R9: the coefficient select is frozen once reset is released.
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
    // R4: x[n-1] is the x[n] of the previous strobe.
    a_r4_prev_input: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> x_q == $past(x_new));
endmodule

// File: rtl/fsk_discrim.sv
// Delay-multiply tone discriminator (top). It multiplies each sample by the
// sample LAG strobes earlier, low-pass filters the product, slices the result
// by sign, and keeps a history of the sliced bits.
// Assumes: one sample per smp_valid_i pulse, and filt_frac_i steady during reset.
module fsk_discrim
    import afskd_pkg::*;
#(
    parameter int unsigned SMP_W  = SMP_W_DEF,
    parameter int unsigned LAG    = LAG_DEF,
    parameter int unsigned ACC_W  = ACC_W_DEF,
    parameter int unsigned HIST_W = HIST_W_DEF,
    parameter int unsigned PSHIFT = PSHIFT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_frac_i,
    input  logic              smp_valid_i,
    input  logic [SMP_W-1:0]  smp_i,
    output logic              bit_o,
    output logic              bit_valid_o,
    output logic [HIST_W-1:0] hist_o
);
    logic signed [SMP_W-1:0] lagged;
    logic signed [ACC_W-1:0] y_next, y_held;
    logic                    slice;

    afskd_delay #(.W(SMP_W), .LAG(LAG)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (smp_valid_i),
        .din_i   ($signed(smp_i)),
        .tap_o   (lagged)
    );

    afskd_lpf #(.IN_W(SMP_W), .ACC_W(ACC_W), .PSHIFT(PSHIFT)) u_lpf (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_cfg_i (filt_frac_i),
        .step_i     (smp_valid_i),
        .a_i        ($signed(smp_i)),
        .b_i        (lagged),
        .y_next_o   (y_next),
        .y_o        (y_held)
    );

    // Sign slicer: strictly positive gives 1.
    assign slice = !y_next[ACC_W-1] && (y_next != '0);

    // Register the sliced bit, its strobe and the bit history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o       <= 1'b0;
            bit_valid_o <= 1'b0;
            hist_o      <= '0;
        end else begin
            bit_valid_o <= smp_valid_i;
            if (smp_valid_i) begin
                bit_o  <= slice;
                hist_o <= {hist_o[HIST_W-2:0], slice};
            end
        end
    end

    // R2: a strobe in gives a strobe out one cycle later, and only then.
    a_r2_strobe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> bit_valid_o);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> !bit_valid_o);
    a_r2_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> $stable(hist_o) && $stable(bit_o));
    // R8: older bits move up by one on every strobe.
    a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0]));
    // R7: the registered bit agrees with the sign of the held filter state.
    a_r7_slice_sign: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> bit_o == (!y_held[ACC_W-1] && (y_held != '0)));
endmodule

// File: tb/fsk_discrim_tb_top.sv
`timescale 1ns/1ps
module fsk_discrim_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt_frac_i = 1'b0;
    logic       smp_valid_i = 1'b0;
    logic [7:0] smp_i = '0;
    logic       bit_o, bit_valid_o;
    logic [7:0] hist_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fsk_discrim dut_i (
        .clk(clk), .rst_n(rst_n), .filt_frac_i(filt_frac_i),
        .smp_valid_i(smp_valid_i), .smp_i(smp_i),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o), .hist_o(hist_o)
    );

    // Independent reference model, using plain integer arithmetic.
    int       m_d [4];
    int       m_x, m_y;
    bit       m_alt;
    bit [7:0] m_h;
    bit [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset(input bit alt);
        for (int i = 0; i < 4; i++) m_d[i] = 0;
        m_x = 0; m_y = 0; m_h = '0; m_alt = alt;
    endtask

    function automatic bit model_step(input int s);
        int d, p, xn, fb, yn;
        bit b;
        d = m_d[3];
        for (int i = 3; i > 0; i--) m_d[i] = m_d[i-1];
        m_d[0] = s;
        p  = s * d;
        xn = p >>> 2;
        fb = m_y >>> 1;
        if (m_alt) fb = fb + (m_y >>> 3) + (m_y >>> 5);
        yn = xn + m_x + fb;
        m_x = xn; m_y = yn;
        b = (yn > 0);
        m_h = {m_h[6:0], b};
        return b;
    endfunction

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr[7:0]));
    endfunction

    task automatic do_reset(input bit alt);
        @(negedge clk);
        rst_n = 1'b0; filt_frac_i = alt; smp_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(alt);
    endtask

    // Send one sample and compare the strobe, bit and history with the model.
    task automatic send(input int s, input string req);
        bit eb;
        @(negedge clk);
        smp_valid_i = 1'b1; smp_i = s[7:0];
        eb = model_step(s);
        @(negedge clk);
        smp_valid_i = 1'b0;
        check(bit_valid_o == 1'b1, "R2", int'(bit_valid_o), 1);
        check(bit_o == eb, req, int'(bit_o), int'(eb));
        check(hist_o == m_h, "R8", int'(hist_o), int'(m_h));
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check(bit_o == 1'b0 && bit_valid_o == 1'b0, "R1", int'({bit_o, bit_valid_o}), 0);
        check(hist_o == 8'h00, "R1", int'(hist_o), 0);
    endtask

    task automatic t_warmup();
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) send(100, "R3");
        check(hist_o == 8'h00, "R3", int'(hist_o), 0);
        send(100, "R7");
        check(bit_o == 1'b1, "R3", int'(bit_o), 1);
    endtask

    // x goes 1 then floor(-3/4) = -1, so y = 1 then 0, and the bits are 1 then 0.
    task automatic t_shift();
        do_reset(1'b0);
        send(2, "R4"); send(1, "R4"); send(0, "R4"); send(0, "R4");
        send(2, "R4"); send(-3, "R4");
        check(hist_o == 8'h02, "R4", int'(hist_o), 2);
        check(bit_o == 1'b0, "R7", int'(bit_o), 0);
    endtask

    task automatic t_tones();
        do_reset(1'b0);
        for (int n = 0; n < 48; n++)
            send($rtoi(100.0 * $cos(2.0 * 3.14159265 * 1200.0 * n / 9600.0)), "R5");
        check(hist_o == 8'h00, "R5", int'(hist_o), 0);
        for (int n = 0; n < 48; n++)
            send($rtoi(100.0 * $cos(2.0 * 3.14159265 * 2200.0 * n / 9600.0)), "R5");
        check(hist_o == 8'hFF, "R5", int'(hist_o), 255);
    endtask

    task automatic t_random(input bit alt);
        do_reset(alt);
        for (int n = 0; n < 150; n++) send(next_rand(), alt ? "R6" : "R5");
    endtask

    task automatic t_fullscale(input bit alt);
        do_reset(alt);
        for (int n = 0; n < 24; n++) send(-128, "R10");
        check(hist_o == 8'hFF, "R10", int'(hist_o), 255);
    endtask

    task automatic t_mode_lock();
        do_reset(1'b0);
        @(negedge clk); filt_frac_i = 1'b1;
        for (int n = 0; n < 120; n++) send(next_rand(), "R9");
        do_reset(1'b1);
        @(negedge clk); filt_frac_i = 1'b0;
        for (int n = 0; n < 120; n++) send(next_rand(), "R9");
    endtask

    task automatic t_idle();
        logic [7:0] h0;
        logic       b0;
        do_reset(1'b0);
        for (int n = 0; n < 9; n++) send(next_rand(), "R5");
        h0 = hist_o; b0 = bit_o;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            check(bit_valid_o == 1'b0, "R2", int'(bit_valid_o), 0);
            check(hist_o == h0 && bit_o == b0, "R2", int'(hist_o), int'(h0));
        end
        // Reset after activity clears everything again.
        do_reset(1'b0);
        check(hist_o == 8'h00 && bit_o == 1'b0, "R1", int'(hist_o), 0);
    endtask

    initial begin
        t_reset_state();
        t_warmup();
        t_shift();
        t_tones();
        t_random(1'b0);
        t_random(1'b1);
        t_fullscale(1'b0);
        t_fullscale(1'b1);
        t_mode_lock();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule